// File: doc/BRIEF.md
# Host Command Request and Reply Queue Port

This block sits on the device side of a 32-bit memory-mapped register bus. The host hands work to the device by writing command addresses to a request port. Each write lands in an inbound queue, and a device-side consumer drains that queue with a valid/ready handshake. The device posts completion tags into an outbound reply queue with its own valid/ready handshake. The host collects them by reading a reply port, and each read consumes one entry.

A reply-pending status bit drives a single interrupt line, gated by a mask register. The mask register has inverted polarity: writing zero lets the interrupt through, and reset leaves it masked. A build-time switch moves the mask and pending bit from bit 3 to bit 2.

The block also has a doorbell register that the device can see, and a scratchpad that reports whether the device has come up. Bus reads are registered: read data appears on `bus_rdata` after the clock edge that samples `bus_re`, and it holds until the next read.

Top module: `mmio_queue_port`

## Requirements
- R1: A bus write to offset 0x40 appends `bus_wdata` to a 16-entry request queue. The device sees the oldest entry on `req_data` while `req_valid` is high, and that entry leaves the queue on a clock edge where `req_valid` and `req_ready` are both high.
- R2: A write to 0x40 while the request queue already holds 16 entries is dropped. It also sets an overflow flag that stays set until reset and reads as bit 8 of the status register.
- R3: A bus read of offset 0x44 removes the oldest reply entry. That entry appears on `bus_rdata` after the same edge.
- R4: A read of 0x44 while the reply queue is empty returns 0xFFFFFFFF and leaves every queue and register unchanged.
- R5: The device adds `rsp_data` to the 16-entry reply queue on an edge where `rsp_valid` and `rsp_ready` are both high. `rsp_ready` is low exactly while the queue holds 16 entries.
- R6: The status register at 0x30 reads the pending bit as 1 while the reply queue is non-empty, and bit 8 as the overflow flag. All other bits read 0, and bus writes to it have no effect.
- R7: A write to the mask register at 0x34 stores bit P of `bus_wdata` as the mask. A read returns the mask at bit P and zeros elsewhere. Reset leaves the mask set, which reads 0x08 with P=3.
- R8: `irq` is high exactly when the reply queue is non-empty and the mask is clear.
- R9: With `ALT_LAYOUT`=1, bit position P is 2 for both the mask and the pending bit. With `ALT_LAYOUT`=0, P is 3.
- R10: The scratchpad at 0xB0 reads 0 until `dev_ready` has been high at a clock edge. From then on it reads 0xFFFF0000.
- R11: The doorbell register at 0x20 is a 32-bit read/write register that resets to 0, and its value drives the `doorbell` output.
- R12: A read of any other offset, including the write-only request port 0x40, returns 0. Writes to 0x30, 0xB0 and unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| req_valid | output | 1 | Request queue holds an entry |
| req_ready | input | 1 | Device takes the head request |
| req_data | output | 32 | Oldest command address |
| rsp_valid | input | 1 | Device offers a reply tag |
| rsp_ready | output | 1 | Reply queue has room |
| rsp_data | input | 32 | Reply tag from the device |
| dev_ready | input | 1 | Device signals it has come up |
| doorbell | output | 32 | Current doorbell register value |
| irq | output | 1 | Reply interrupt |

## Verification
The bench builds two copies side by side from the same stimulus. One uses `ALT_LAYOUT`=0 and the other `ALT_LAYOUT`=1, both with the default depth of 16. Because the two copies share one stimulus, a single mask write such as 0x08 masks one copy and unmasks the other, so the polarity and bit position of both layouts are checked on the same traffic. A depth of 16 keeps both queue-full boundaries within a few dozen cycles. Those boundaries are overflow on the request side and back-pressure on the reply side, and each is exercised both directed and under random traffic against a queue-based model.

// File: rtl/mqp_pkg.sv
`timescale 1ns/1ps
package mqp_pkg;
    localparam int DATA_W = 32;

    // byte offsets of the host-visible registers
    localparam int OFF_DOORBELL = 'h20;
    localparam int OFF_STATUS   = 'h30;
    localparam int OFF_MASK     = 'h34;
    localparam int OFF_REQUEST  = 'h40;
    localparam int OFF_REPLY    = 'h44;
    localparam int OFF_SCRATCH  = 'hB0;

    localparam logic [DATA_W-1:0] EMPTY_WORD = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] READY_WORD = 32'hFFFF_0000;

    localparam int OVF_BIT = 8;

    function automatic int pend_bit(input bit alt);
        return alt ? 2 : 3;
    endfunction
endpackage

// File: rtl/mqp_fifo.sv
`timescale 1ns/1ps
module mqp_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic     do_push, do_pop;

    assign full  = (s_q.cnt == FULL_CNT);
    assign empty = (s_q.cnt == '0);
    assign head  = s_q.mem[s_q.rd];

    always_comb begin
        s_d     = s_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            s_d.mem[s_q.wr] = push_data;
            s_d.wr = (s_q.wr == LAST) ? '0 : s_q.wr + 1'b1;
        end
        if (do_pop) begin
            s_d.rd = (s_q.rd == LAST) ? '0 : s_q.rd + 1'b1;
        end
        if (do_push && !do_pop) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mqp_irq.sv
`timescale 1ns/1ps
module mqp_irq #(
    parameter int PEND_BIT = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mask_we,
    input  logic        mask_wbit,
    input  logic        pending,
    output logic [31:0] mask_word,
    output logic        irq
);
    typedef struct packed {
        logic masked;
    } irq_st_t;

    irq_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mask_we) begin
            s_d.masked = mask_wbit;
        end
    end

    always_comb begin
        mask_word           = '0;
        mask_word[PEND_BIT] = s_q.masked;
        irq                 = pending && !s_q.masked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.masked <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mmio_queue_port.sv
`timescale 1ns/1ps
module mmio_queue_port #(
    parameter int ADDR_W     = 8,
    parameter int DEPTH      = 16,
    parameter bit ALT_LAYOUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [31:0]       req_data,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [31:0]       rsp_data,
    input  logic              dev_ready,
    output logic [31:0]       doorbell,
    output logic              irq
);
    import mqp_pkg::*;

    localparam int PEND_BIT = pend_bit(ALT_LAYOUT);
    localparam logic [ADDR_W-1:0] A_DOORBELL = ADDR_W'(OFF_DOORBELL);
    localparam logic [ADDR_W-1:0] A_STATUS   = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK     = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_REQUEST  = ADDR_W'(OFF_REQUEST);
    localparam logic [ADDR_W-1:0] A_REPLY    = ADDR_W'(OFF_REPLY);
    localparam logic [ADDR_W-1:0] A_SCRATCH  = ADDR_W'(OFF_SCRATCH);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] doorbell;
        logic              ovf;
        logic              ready;
    } port_st_t;

    port_st_t s_d, s_q;

    logic        req_full, req_empty;
    logic        rsp_full, rsp_empty;
    logic [31:0] rsp_head;
    logic [31:0] mask_word;
    logic [31:0] status_word;
    logic        hit_req_wr, hit_rsp_rd, hit_mask_wr;

    assign hit_req_wr  = bus_we && (bus_addr == A_REQUEST);
    assign hit_rsp_rd  = bus_re && (bus_addr == A_REPLY);
    assign hit_mask_wr = bus_we && (bus_addr == A_MASK);

    // inbound: host writes, device drains
    mqp_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_req_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (hit_req_wr),
        .push_data (bus_wdata),
        .pop       (req_valid && req_ready),
        .head      (req_data),
        .full      (req_full),
        .empty     (req_empty)
    );

    // outbound: device fills, host reads
    mqp_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rsp_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rsp_valid),
        .push_data (rsp_data),
        .pop       (hit_rsp_rd),
        .head      (rsp_head),
        .full      (rsp_full),
        .empty     (rsp_empty)
    );

    mqp_irq #(.PEND_BIT(PEND_BIT)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we   (hit_mask_wr),
        .mask_wbit (bus_wdata[PEND_BIT]),
        .pending   (!rsp_empty),
        .mask_word (mask_word),
        .irq       (irq)
    );

    assign req_valid = !req_empty;
    assign rsp_ready = !rsp_full;
    assign bus_rdata = s_q.rdata;
    assign doorbell  = s_q.doorbell;

    always_comb begin
        status_word           = '0;
        status_word[PEND_BIT] = !rsp_empty;
        status_word[OVF_BIT]  = s_q.ovf;
    end

    always_comb begin
        s_d = s_q;
        if (hit_req_wr && req_full) begin
            s_d.ovf = 1'b1;
        end
        if (dev_ready) begin
            s_d.ready = 1'b1;
        end
        if (bus_we && (bus_addr == A_DOORBELL)) begin
            s_d.doorbell = bus_wdata;
        end
        if (bus_re) begin
            case (bus_addr)
                A_DOORBELL: s_d.rdata = s_q.doorbell;
                A_STATUS:   s_d.rdata = status_word;
                A_MASK:     s_d.rdata = mask_word;
                A_REPLY:    s_d.rdata = rsp_empty ? EMPTY_WORD : rsp_head;
                A_SCRATCH:  s_d.rdata = s_q.ready ? READY_WORD : '0;
                default:    s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mqp_checker.sv
`timescale 1ns/1ps
module mqp_checker #(
    parameter int ADDR_W   = 8,
    parameter int PEND_BIT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic              req_valid,
    input logic              req_ready,
    input logic [31:0]       req_data,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              irq,
    input logic              req_full,
    input logic              rsp_empty,
    input logic              ovf_flag,
    input logic              mask_on
);
    import mqp_pkg::*;

    logic rd_reply, rd_status, wr_req;
    assign rd_reply  = bus_re && (bus_addr == ADDR_W'(OFF_REPLY));
    assign rd_status = bus_re && (bus_addr == ADDR_W'(OFF_STATUS));
    assign wr_req    = bus_we && (bus_addr == ADDR_W'(OFF_REQUEST));

    assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_data)));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && req_full) |=> ovf_flag);

    assert_ovf_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_reply && rsp_empty && !rsp_valid) |=> (rsp_empty && bus_rdata == EMPTY_WORD));

    assert_reply_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> !rsp_empty);

    assert_status_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |=> (bus_rdata[PEND_BIT] == !$past(rsp_empty)));

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!rsp_empty && !mask_on));

    assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_empty && !mask_on) |-> irq);
endmodule

bind mmio_queue_port mqp_checker #(.ADDR_W(ADDR_W), .PEND_BIT(PEND_BIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_data  (req_data),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .irq       (irq),
    .req_full  (req_full),
    .rsp_empty (rsp_empty),
    .ovf_flag  (s_q.ovf),
    .mask_on   (mask_word[PEND_BIT])
);

// File: tb/tb_mmio_queue_port.sv
`timescale 1ns/1ps
module tb_mmio_queue_port;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic        req_ready = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        dev_ready = 1'b0;

    logic [31:0] rdata, rdata_a, req_data, req_data_a, db, db_a;
    logic        req_valid, req_valid_a, rsp_ready, rsp_ready_a, irq, irq_a;

    always #2 clk = ~clk;

    mmio_queue_port #(.ADDR_W(8), .DEPTH(DEPTH), .ALT_LAYOUT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .dev_ready(dev_ready), .doorbell(db), .irq(irq)
    );

    mmio_queue_port #(.ADDR_W(8), .DEPTH(DEPTH), .ALT_LAYOUT(1'b1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(rdata_a),
        .req_valid(req_valid_a), .req_ready(req_ready), .req_data(req_data_a),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready_a), .rsp_data(rsp_data),
        .dev_ready(dev_ready), .doorbell(db_a), .irq(irq_a)
    );

    // reference model
    logic [31:0] m_req[$];
    logic [31:0] m_rsp[$];
    bit          m_mask = 1'b1;
    bit          m_mask_a = 1'b1;
    bit          m_ovf = 1'b0;
    bit          m_rdy = 1'b0;
    logic [31:0] m_db = '0;
    logic [31:0] m_rd = '0;
    logic [31:0] m_rd_a = '0;
    string       rd_tag = "R12";
    int          total = 0;
    int          bad = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input int pb, input bit msk);
        logic [31:0] v;
        v = '0;
        case (bus_addr)
            8'h20: v = m_db;
            8'h30: begin v[pb] = (m_rsp.size() != 0); v[8] = m_ovf; end
            8'h34: v[pb] = msk;
            8'h44: v = (m_rsp.size() != 0) ? m_rsp[0] : 32'hFFFF_FFFF;
            8'hB0: v = m_rdy ? 32'hFFFF_0000 : 32'h0;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic model_edge();
        int  nreq, nrsp;
        bit  req_pop, rsp_pop, req_push;
        nreq = m_req.size();
        nrsp = m_rsp.size();
        if (bus_re) begin
            m_rd   = model_read(3, m_mask);
            m_rd_a = model_read(2, m_mask_a);
            case (bus_addr)
                8'h20: rd_tag = "R11 doorbell read";
                8'h30: rd_tag = "R6/R2 status read";
                8'h34: rd_tag = "R7 mask read";
                8'h44: rd_tag = (nrsp != 0) ? "R3 reply pop" : "R4 empty reply read";
                8'hB0: rd_tag = "R10 scratchpad read";
                default: rd_tag = "R12 unmapped read";
            endcase
        end
        req_pop  = (nreq > 0) && req_ready;
        rsp_pop  = bus_re && (bus_addr == 8'h44) && (nrsp > 0);
        req_push = bus_we && (bus_addr == 8'h40);
        if (req_pop) void'(m_req.pop_front());
        if (req_push) begin
            if (nreq < DEPTH) m_req.push_back(bus_wdata);
            else m_ovf = 1'b1;
        end
        if (rsp_pop) void'(m_rsp.pop_front());
        if (rsp_valid && nrsp < DEPTH) m_rsp.push_back(rsp_data);
        if (bus_we && bus_addr == 8'h34) begin
            m_mask   = bus_wdata[3];
            m_mask_a = bus_wdata[2];
        end
        if (bus_we && bus_addr == 8'h20) m_db = bus_wdata;
        if (dev_ready) m_rdy = 1'b1;
    endtask

    task automatic compare_all();
        check("R1 req_valid", {31'd0, req_valid}, {31'd0, m_req.size() != 0});
        if (m_req.size() != 0) check("R1 req_data order", req_data, m_req[0]);
        check("R5 rsp_ready", {31'd0, rsp_ready}, {31'd0, m_rsp.size() < DEPTH});
        check("R8 irq", {31'd0, irq}, {31'd0, (m_rsp.size() != 0) && !m_mask});
        check("R9 alt irq", {31'd0, irq_a}, {31'd0, (m_rsp.size() != 0) && !m_mask_a});
        check(rd_tag, rdata, m_rd);
        check({"R9 alt ", rd_tag}, rdata_a, m_rd_a);
        check("R11 doorbell out", db, m_db);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a);
        bus_addr = a; bus_re = 1'b1;
        step();
        bus_re = 1'b0;
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL R1 watchdog expired act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // reset state: R1 empty, R5 room, R8 masked, R11 doorbell 0
        compare_all();

        // R7 reset mask, R6 empty status, R10 before ready, R12 unmapped
        bus_read(8'h34);
        bus_read(8'h30);
        bus_read(8'hB0);
        bus_read(8'h00);
        bus_read(8'h40);

        // R10 ready becomes sticky
        dev_ready = 1'b1;
        step();
        dev_ready = 1'b0;
        bus_read(8'hB0);
        step();
        bus_read(8'hB0);

        // R11 doorbell
        bus_write(8'h20, 32'hA5A5_0F0F);
        bus_read(8'h20);

        // R6/R12 writes to read-only offsets ignored
        bus_write(8'h30, 32'hFFFF_FFFF);
        bus_write(8'hB0, 32'h0);
        bus_write(8'hFC, 32'h1234_5678);
        bus_read(8'h30);
        bus_read(8'hB0);
        bus_read(8'hFC);

        // R1 requests in order
        for (int i = 0; i < 3; i++) bus_write(8'h40, 32'h1000 + i);
        req_ready = 1'b1;
        repeat (4) step();
        req_ready = 1'b0;

        // R2 overflow: fill then two more
        for (int i = 0; i < DEPTH + 2; i++) bus_write(8'h40, 32'h2000 + i);
        bus_read(8'h30);
        for (int i = 0; i < 20; i++) begin
            req_ready = i[0];
            step();
        end
        req_ready = 1'b1;
        repeat (12) step();
        req_ready = 1'b0;
        bus_read(8'h30);

        // R4 empty reply read
        bus_read(8'h44);
        bus_read(8'h44);

        // R5 replies; R8 masked by reset
        for (int i = 0; i < 3; i++) begin
            rsp_valid = 1'b1; rsp_data = 32'hC000 + i;
            step();
        end
        rsp_valid = 1'b0;
        bus_read(8'h30);
        // R7/R8/R9 polarity
        bus_write(8'h34, 32'h0);
        bus_read(8'h34);
        bus_write(8'h34, 32'h8);
        bus_read(8'h34);
        bus_write(8'h34, 32'h4);
        bus_read(8'h34);
        bus_write(8'h34, 32'h0);
        // R3 pops
        for (int i = 0; i < 4; i++) bus_read(8'h44);

        // R5 back-pressure
        rsp_valid = 1'b1;
        for (int i = 0; i < DEPTH + 3; i++) begin
            rsp_data = 32'hD000 + i;
            step();
        end
        // R3 pop while device keeps pushing
        for (int i = 0; i < 3; i++) begin
            rsp_data = 32'hE000 + i;
            bus_read(8'h44);
        end
        rsp_valid = 1'b0;
        for (int i = 0; i < DEPTH + 2; i++) bus_read(8'h44);

        // random traffic across R1..R12
        for (int i = 0; i < 3000; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            bus_we = 1'b0; bus_re = 1'b0;
            case ($urandom_range(0, 6))
                0: bus_addr = 8'h20;
                1: bus_addr = 8'h30;
                2: bus_addr = 8'h34;
                3: bus_addr = 8'h40;
                4: bus_addr = 8'h44;
                5: bus_addr = 8'hB0;
                default: bus_addr = 8'h10;
            endcase
            if (sel < 4) bus_we = 1'b1;
            else if (sel < 8) bus_re = 1'b1;
            bus_wdata = $urandom();
            if (bus_addr == 8'h34) bus_wdata = $urandom_range(0, 15);
            req_ready = ($urandom_range(0, 2) == 0);
            rsp_valid = ($urandom_range(0, 1) == 0);
            rsp_data  = $urandom();
            step();
        end
        bus_we = 1'b0; bus_re = 1'b0; rsp_valid = 1'b0; req_ready = 1'b0;
        step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule